// File: doc/BRIEF.md
# Carry-Sensing Microcode ALU

This block is the arithmetic and write-back selection stage of a small microcoded datapath. Each micro-step presents two operands, a carry-in, an operation code and a result-source code. Within the same cycle the block returns the value to be written back to the register set, together with a carry-out that the microsequencer can branch on. It is purely combinational and holds no state.

All arithmetic operations share one adder. Bitwise AND and OR are computed next to it. A pass operation copies operand A, or increments it when carry-in is set. A decrement of A gives a carry-out of 0 exactly when A was zero, so a single micro-step can test a register for zero.

The write-back value can come from the ALU, from an 8-bit immediate field, from the low four bits of that field zero-extended, or from the memory data register. The carry-out always follows the ALU operation, whichever source is selected. This lets a branch step decrement a register and place a short immediate on the result bus in the same cycle.

Top module: `ualu_core`

## Requirements
- R1: Operation code 0 (AND) gives the bitwise AND of A and B, with carry-out 0.
- R2: Operation code 1 (OR) gives the bitwise OR of A and B, with carry-out 0.
- R3: Operation code 2 (ADD) gives the low 8 bits of A+B+carry-in. Carry-out is 1 exactly when that sum exceeds 255.
- R4: Operation code 3 (SUB) gives (A−B) mod 256 with carry-out 1 iff A≥B when carry-in is 1. It gives (A−B−1) mod 256 with carry-out 1 iff A>B when carry-in is 0.
- R5: Operation code 4 (pass) with carry-in 0 returns A unchanged, with carry-out 0.
- R6: Operation code 4 with carry-in 1 returns (A+1) mod 256. Carry-out is 1 only when A is 255.
- R7: Operation code 5 (decrement) returns (A−1) mod 256. Carry-out is 1 iff A is nonzero. Carry-in and B have no effect on either output.
- R8: Operation codes 6 and 7 are reserved and give result 0 and carry-out 0.
- R9: Source code 0 selects the ALU result. Code 1 selects the full 8-bit immediate. Code 2 selects immediate bits 3:0 with bits 7:4 forced to zero. Code 3 selects the memory data value.
- R10: The carry-out depends only on the operands, the carry-in and the operation code. The source code never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| carry_in | input | 1 | Carry into the shared adder |
| op_sel | input | 3 | Operation code (see R1–R8) |
| src_sel | input | 2 | Write-back source code (see R9) |
| imm_field | input | 8 | Immediate bits taken from the instruction word |
| mdr_val | input | 8 | Memory data register contents |
| wb_value | output | 8 | Value to be written back |
| carry_out | output | 1 | Carry flag for the sequencer |

## Verification
The overlap that matters is a branch step. In that step a decrement drives the carry-out while the short immediate, not the ALU result, drives the write-back bus. The bench provokes it by sweeping every value of A through the decrement with each non-ALU source selected. It checks that the write-back equals the chosen source while the carry-out still reports whether A was zero. The same vectors also repeat under the full immediate and memory-data sources, so a carry path wrongly gated by the source selection shows up.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_PASS = 3'd4,
        OP_DEC  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ALU  = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_NIB  = 2'd2,
        SRC_MDR  = 2'd3
    } wb_src_e;

    // How the second adder input and its carry are formed
    typedef enum logic [1:0] {
        BSEL_DIRECT = 2'd0,
        BSEL_INVERT = 2'd1,
        BSEL_ZERO   = 2'd2,
        BSEL_ONES   = 2'd3
    } b_form_e;

    typedef struct packed {
        b_form_e b_form;
        logic    use_cin;
    } prep_ctl_t;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_PASS) || (op == OP_DEC);
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR);
    endfunction

    function automatic prep_ctl_t prep_decode(alu_op_e op);
        prep_ctl_t c;
        unique case (op)
            OP_ADD:  c = '{b_form: BSEL_DIRECT, use_cin: 1'b1};
            OP_SUB:  c = '{b_form: BSEL_INVERT, use_cin: 1'b1};
            OP_PASS: c = '{b_form: BSEL_ZERO,   use_cin: 1'b1};
            OP_DEC:  c = '{b_form: BSEL_ONES,   use_cin: 1'b0};
            default: c = '{b_form: BSEL_ZERO,   use_cin: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ualu_operand_prep.sv
module ualu_operand_prep
    import ualu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   b_in,
    input  logic            cin,
    output logic [DW-1:0]   add_b,
    output logic            add_cin
);

    prep_ctl_t ctl;

    always_comb begin
        ctl = prep_decode(op);
        unique case (ctl.b_form)
            BSEL_DIRECT: add_b = b_in;
            BSEL_INVERT: add_b = ~b_in;
            BSEL_ONES:   add_b = '1;
            default:     add_b = '0;
        endcase
        add_cin = ctl.use_cin & cin;
    end

    // Decrement must ignore the incoming carry (R7)
    always_comb begin : chk_prep
        if (op == OP_DEC) begin
            p_dec_cin_blocked_r7: assert (!add_cin && (&add_b))
                else $error("decrement adder inputs wrong");
        end
    end

endmodule

// File: rtl/ualu_ripple_adder.sv
module ualu_ripple_adder #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout
);

    always_comb begin
        logic carry;
        carry = cin;
        for (int i = 0; i < DW; i++) begin
            sum[i] = a[i] ^ b[i] ^ carry;
            carry  = (a[i] & b[i]) | (carry & (a[i] ^ b[i]));
        end
        cout = carry;
    end

endmodule

// File: rtl/ualu_logic_unit.sv
module ualu_logic_unit #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] and_out,
    output logic [DW-1:0] or_out
);

    for (genvar gi = 0; gi < DW; gi++) begin : g_bit
        assign and_out[gi] = a[gi] & b[gi];
        assign or_out[gi]  = a[gi] | b[gi];
    end

endmodule

// File: rtl/ualu_result_mux.sv
module ualu_result_mux
    import ualu_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned NIB_W = 4
) (
    input  wb_src_e         src,
    input  logic [DW-1:0]   alu_res,
    input  logic [DW-1:0]   imm,
    input  logic [DW-1:0]   mdr,
    output logic [DW-1:0]   wb
);

    localparam int unsigned PAD_W = DW - NIB_W;

    logic [DW-1:0] nib_ext;
    assign nib_ext = {{PAD_W{1'b0}}, imm[NIB_W-1:0]};

    always_comb begin
        unique case (src)
            SRC_ALU: wb = alu_res;
            SRC_IMM: wb = imm;
            SRC_NIB: wb = nib_ext;
            default: wb = mdr;
        endcase
    end

    always_comb begin : chk_mux
        if (src == SRC_NIB) begin
            p_nib_zero_ext_r9: assert (wb[DW-1:NIB_W] == '0 && wb[NIB_W-1:0] == imm[NIB_W-1:0])
                else $error("short immediate not zero-extended");
        end
        if (src == SRC_MDR) begin
            p_mdr_select_r9: assert (wb == mdr)
                else $error("memory data not selected");
        end
    end

endmodule

// File: rtl/ualu_core.sv
module ualu_core
    import ualu_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned NIB_W = 4
) (
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    input  logic [2:0]    op_sel,
    input  logic [1:0]    src_sel,
    input  logic [DW-1:0] imm_field,
    input  logic [DW-1:0] mdr_val,
    output logic [DW-1:0] wb_value,
    output logic          carry_out
);

    alu_op_e       op;
    wb_src_e       src;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] sum;
    logic          sum_cout;
    logic [DW-1:0] and_out;
    logic [DW-1:0] or_out;
    logic [DW-1:0] alu_res;

    assign op  = alu_op_e'(op_sel);
    assign src = wb_src_e'(src_sel);

    ualu_operand_prep #(.DW(DW)) prep_i (
        .op      (op),
        .b_in    (opnd_b),
        .cin     (carry_in),
        .add_b   (add_b),
        .add_cin (add_cin)
    );

    ualu_ripple_adder #(.DW(DW)) adder_i (
        .a    (opnd_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (sum),
        .cout (sum_cout)
    );

    ualu_logic_unit #(.DW(DW)) logic_i (
        .a       (opnd_a),
        .b       (opnd_b),
        .and_out (and_out),
        .or_out  (or_out)
    );

    always_comb begin
        if (op_is_arith(op)) begin
            alu_res   = sum;
            carry_out = sum_cout;
        end else if (op_is_logic(op)) begin
            alu_res   = (op == OP_AND) ? and_out : or_out;
            carry_out = 1'b0;
        end else begin
            alu_res   = '0;
            carry_out = 1'b0;
        end
    end

    ualu_result_mux #(.DW(DW), .NIB_W(NIB_W)) mux_i (
        .src     (src),
        .alu_res (alu_res),
        .imm     (imm_field),
        .mdr     (mdr_val),
        .wb      (wb_value)
    );

    always_comb begin : chk_core
        if (op == OP_DEC) begin
            p_zero_sense_r7: assert (carry_out == (opnd_a != '0))
                else $error("decrement carry does not sense zero");
        end
        if (op == OP_PASS && !carry_in && src == SRC_ALU) begin
            p_pass_through_r5: assert (wb_value == opnd_a && !carry_out)
                else $error("pass did not copy A");
        end
        if (op == OP_AND || op == OP_OR) begin
            p_logic_no_carry_r1: assert (!carry_out)
                else $error("logic op raised carry");
        end
        if ((op == OP_RSV6 || op == OP_RSV7) && src == SRC_ALU) begin
            p_reserved_zero_r8: assert (wb_value == '0 && !carry_out)
                else $error("reserved op not zero");
        end
    end

endmodule

// File: tb/ualu_core_tb_top.sv
module ualu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a, b, imm, mdr;
    logic       cin;
    logic [2:0] op;
    logic [1:0] src;
    logic [7:0] wb;
    logic       cout;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    localparam int WATCHDOG = 150000;

    always #2 clk = ~clk;

    ualu_core dut_i (
        .opnd_a    (a),
        .opnd_b    (b),
        .carry_in  (cin),
        .op_sel    (op),
        .src_sel   (src),
        .imm_field (imm),
        .mdr_val   (mdr),
        .wb_value  (wb),
        .carry_out (cout)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic expect_eq(string tag, int act, int exp, string what);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            if (errors < 20)
                $display("FAIL %s %s: actual=%0d expected=%0d (a=%0d b=%0d cin=%0d op=%0d src=%0d)",
                         tag, what, act, exp, a, b, cin, op, src);
        end
    endtask

    // Arithmetic reference derived from the requirements
    task automatic ref_alu(input int ia, input int ib, input int ic, input int iop,
                           output int r, output int c);
        case (iop)
            0: begin r = ia & ib; c = 0; end                       // R1
            1: begin r = ia | ib; c = 0; end                       // R2
            2: begin r = (ia + ib + ic) % 256; c = (ia + ib + ic > 255) ? 1 : 0; end // R3
            3: begin                                                // R4
                if (ic == 1) begin r = (ia - ib + 256) % 256; c = (ia >= ib) ? 1 : 0; end
                else begin r = (ia - ib - 1 + 512) % 256; c = (ia > ib) ? 1 : 0; end
            end
            4: begin r = (ia + ic) % 256; c = (ic == 1 && ia == 255) ? 1 : 0; end // R5 R6
            5: begin r = (ia + 255) % 256; c = (ia != 0) ? 1 : 0; end             // R7
            default: begin r = 0; c = 0; end                        // R8
        endcase
    endtask

    function automatic string op_tag(int iop, int ic);
        case (iop)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return (ic == 1) ? "R6" : "R5";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        int bset [12] = '{0, 1, 2, 15, 16, 85, 127, 128, 170, 240, 254, 255};
        int er, ec;
        a = 0; b = 0; cin = 0; op = 0; src = 0; imm = 0; mdr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // Quiet state: AND of zeros from the ALU source
        expect_eq("R1", int'(wb), 0, "idle result");
        expect_eq("R1", int'(cout), 0, "idle carry");

        // Sweep every op, every A, a spread of B, both carry-ins (R1..R8)
        for (int o = 0; o < 8; o++) begin
            for (int ai = 0; ai < 256; ai++) begin
                for (int bi = 0; bi < 12; bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        @(negedge clk);
                        a = 8'(ai); b = 8'(bset[bi]); cin = ci[0]; op = 3'(o);
                        src = 2'd0; imm = 8'(ai ^ 8'h3C); mdr = 8'(bset[bi] ^ 8'hC3);
                        #1;
                        ref_alu(ai, bset[bi], ci, o, er, ec);
                        expect_eq(op_tag(o, ci), int'(wb), er, "result");
                        expect_eq(op_tag(o, ci), int'(cout), ec, "carry");
                    end
                end
            end
        end

        // Branch overlap: decrement drives carry while another source drives write-back (R9, R10)
        for (int s = 1; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                @(negedge clk);
                a = 8'(v); b = 8'(255 - v); cin = v[0]; op = 3'd5; src = 2'(s);
                imm = 8'(v * 7 + 3); mdr = 8'(~v);
                #1;
                case (s)
                    1: er = (v * 7 + 3) % 256;
                    2: er = (v * 7 + 3) % 16;
                    default: er = 255 - v;
                endcase
                expect_eq("R9", int'(wb), er, "write-back source");
                expect_eq("R10", int'(cout), (v != 0) ? 1 : 0, "carry under non-ALU source");
            end
        end

        // Carry from ADD must also survive a non-ALU source (R10)
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            a = 8'(v); b = 8'd200; cin = 1'b0; op = 3'd2; src = 2'd3; mdr = 8'(v);
            #1;
            expect_eq("R10", int'(cout), (v + 200 > 255) ? 1 : 0, "add carry with memory source");
            expect_eq("R9", int'(wb), v, "memory source value");
        end

        report();
    end

endmodule